// File: doc/BRIEF.md
# Three-Level Activity Watchdog

This block watches a processor's heartbeat line and pulls an active-low alarm output down when the line has stopped changing for longer than a configurable number of clock cycles. The heartbeat arrives as two bits from an external three-level detector: a data level and a flag that says the line is left undriven. An undriven line switches the timer off. Software keeps the alarm high by flipping the data level in either direction before the period runs out.

The block also takes two signals from the supply supervisor: a flag that says the supply is under its threshold, and that supervisor's active-low reset. While the supervisor holds reset, the timer stays at zero, and a full period begins when reset lets go. While the supply flag is set, the alarm is low whatever the timer holds. With the heartbeat line undriven, the alarm therefore reports low supply only. The alarm never causes a reset by itself.

The heartbeat pair is asynchronous and passes through a synchronizer of `SYNC_STAGES` flops. The supply flag and the supervisor reset are synchronous to `clk`. All ports are plain level signals, and no part of the block uses a handshake.

Top module: `activity_watchdog`

## Requirements
- R1: With the line driven and never toggled, `wd_alarm_n_o` falls exactly `TIMEOUT_CYCLES` clock edges after the clear takes effect. A heartbeat change takes effect on the (`SYNC_STAGES`+1)-th rising edge after it appears on the pins.
- R2: A low-to-high change and a high-to-low change of `hb_level_i` each restart the period, provided `hb_float_i` is 0 both before and after the change.
- R3: While `sup_rst_n_i` is 0, the timer is held at zero and the alarm does not fall from a timeout. After `sup_rst_n_i` returns to 1, the alarm falls on the `TIMEOUT_CYCLES`-th rising edge.
- R4: With `hb_float_i`=1, the timer is disabled. A pending timeout is withdrawn within `SYNC_STAGES`+1 edges, and the alarm never falls from a timeout however long the line stays undriven.
- R5: Once a timeout has occurred, the alarm stays low until a heartbeat change, a return from the undriven state, or a reset clears it.
- R6: `supply_low_i`=1 drives the alarm low in the same cycle, with no clock edge needed, whether or not a timeout has occurred. The flag does not alter the timer count.
- R7: When the line goes from undriven to driven, the period restarts from zero. Entering or leaving the undriven state is never treated as a data change.
- R8: While `rst_n` is 0, the timer and the synchronizer are cleared asynchronously, and the synchronizer treats the line as undriven. The alarm is then high unless `supply_low_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| hb_level_i | input | 1 | Heartbeat data level (asynchronous) |
| hb_float_i | input | 1 | 1 when the detector sees the heartbeat line undriven (asynchronous) |
| supply_low_i | input | 1 | Supply-below-threshold flag (synchronous) |
| sup_rst_n_i | input | 1 | Active-low reset from the supply supervisor (synchronous) |
| wd_alarm_n_o | output | 1 | Active-low watchdog alarm / low-line indicator |

## Verification
A counter that is off by one moves the alarm's falling edge by one cycle against the R1 window. The bench samples both sides of that window after every clear, so an off-by-one shows up at once. A missed clear, whether from the wrong edge polarity, a float exit taken as a data change, or a reset that does not hold, leaves the alarm low when a restarted period should keep it high. The same fault can instead pull the alarm low one period too early. Either way it shows within `TIMEOUT_CYCLES`+`SYNC_STAGES`+1 cycles of the stimulus. If the supply flag disturbs the count, the following timeout edge shifts in time, and the bench checks that timeout edge after every supply pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef struct packed {
    logic level;
    logic flt;
  } hb_line_t;

  localparam hb_line_t HB_IDLE = '{level: 1'b0, flt: 1'b1};
endpackage

// File: rtl/wdg_line_sync.sv
module wdg_line_sync
  import wdg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  hb_line_t line_i,
  output hb_line_t line_o
);
  hb_line_t stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= HB_IDLE;
        else        stage_q[i] <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= HB_IDLE;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign line_o = stage_q[STAGES-1];
endmodule

// File: rtl/wdg_edge_detect.sv
module wdg_edge_detect
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hb_line_t line_i,
  output logic     toggle_o,
  output logic     resume_o
);
  hb_line_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= HB_IDLE;
    else        prev_q <= line_i;
  end

  // A data change counts only when driven on both sides of it.
  assign toggle_o = !line_i.flt && !prev_q.flt && (line_i.level != prev_q.level);
  // Leaving the undriven state restarts the period.
  assign resume_o = prev_q.flt && !line_i.flt;
endmodule

// File: rtl/wdg_period_timer.sv
module wdg_period_timer #(
  parameter int LIMIT = 8,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          off_i,
  input  logic          restart_i,
  output logic          expired_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (hold_i || off_i || restart_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!exp_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) exp_q <= 1'b1;
    end
  end

  assign expired_o = exp_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog
  import wdg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 80_000_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_level_i,
  input  logic hb_float_i,
  input  logic supply_low_i,
  input  logic sup_rst_n_i,
  output logic wd_alarm_n_o
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

  hb_line_t      raw_line;
  hb_line_t      sync_line;
  logic          toggle;
  logic          resume;
  logic          expired;
  logic [CW-1:0] count;

  assign raw_line = '{level: hb_level_i, flt: hb_float_i};

  wdg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (raw_line),
    .line_o (sync_line)
  );

  wdg_edge_detect u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (sync_line),
    .toggle_o (toggle),
    .resume_o (resume)
  );

  wdg_period_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (!sup_rst_n_i),
    .off_i     (sync_line.flt),
    .restart_i (toggle || resume),
    .expired_o (expired),
    .count_o   (count)
  );

  assign wd_alarm_n_o = !(expired || supply_low_i);
endmodule

// File: rtl/activity_watchdog_checker.sv
module activity_watchdog_checker #(
  parameter int TIMEOUT_CYCLES = 8,
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_low_i,
  input logic          sup_rst_n_i,
  input logic          wd_alarm_n_o,
  input logic          expired,
  input logic [CW-1:0] count,
  input logic          flt,
  input logic          toggle,
  input logic          resume
);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYCLES);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIM); // R1
  AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(count) == LIM - 1'b1); // R1
  AST_BOTH_EDGES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> !expired && count == '0); // R2
  AST_SUP_RESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_rst_n_i |=> !expired && count == '0); // R3
  AST_FLOAT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    flt |=> !expired); // R4
  AST_ALARM_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    expired && sup_rst_n_i && !flt && !toggle && !resume |=> expired); // R5
  AST_SUPPLY_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low_i |-> !wd_alarm_n_o); // R6
  AST_RESUME_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> count == '0); // R7
endmodule

bind activity_watchdog activity_watchdog_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_low_i (supply_low_i),
  .sup_rst_n_i  (sup_rst_n_i),
  .wd_alarm_n_o (wd_alarm_n_o),
  .expired      (expired),
  .count        (count),
  .flt          (sync_line.flt),
  .toggle       (toggle),
  .resume       (resume)
);

// File: tb/test_activity_watchdog.sv
module test_activity_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int TO  = 8;
  localparam int SYN = 2;

  logic clk = 1'b0;
  logic rst_n, hb_level, hb_float, supply_low, sup_rst_n;
  logic alarm_n;
  int   n_run  = 0;
  int   n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  activity_watchdog #(.TIMEOUT_CYCLES(TO), .SYNC_STAGES(SYN)) i_activity_watchdog (
    .clk          (clk),
    .rst_n        (rst_n),
    .hb_level_i   (hb_level),
    .hb_float_i   (hb_float),
    .supply_low_i (supply_low),
    .sup_rst_n_i  (sup_rst_n),
    .wd_alarm_n_o (alarm_n)
  );

  typedef struct packed {
    logic       lvl;
    logic       flt;
    logic       sl;
    logic       srst_n;
    logic [7:0] wait_n;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // Inputs are applied at a falling edge, wait_n rising edges pass, then the
  // alarm is sampled at the next falling edge.
  localparam vec_t VECS [22] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 1'b1, 4'd1}, // R1 just before expiry
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd1}, // R1 expiry edge
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd5,  1'b0, 4'd5}, // R5 stays low
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd10, 1'b1, 4'd2}, // R2 rising change clears
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd2}, // R2 next expiry
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 1'b1, 4'd2}, // R2 falling change clears
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd2}, // R2 next expiry
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd3,  1'b1, 4'd4}, // R4 float withdraws timeout
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd30, 1'b1, 4'd4}, // R4 never times out
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd1,  1'b0, 4'd6}, // R6 low-line while floating
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 4'd6}, // R6 released
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd10, 1'b1, 4'd7}, // R7 resume restarts at zero
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd7}, // R7 full period after resume
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  1'b1, 4'd5}, // R5 cleared by change
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'd1,  1'b0, 4'd6}, // R6 supply forces low
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b1, 4'd6}, // R6 back high
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  1'b1, 4'd6}, // R6 count undisturbed
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd6}, // R6 expiry on time
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  1'b1, 4'd3}, // R3 reset clears timeout
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 1'b1, 4'd3}, // R3 held in reset
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd7,  1'b1, 4'd3}, // R3 period after release
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd3}  // R3 expiry after release
  };

  task automatic check(input logic exp, input int req, input string what);
    n_run++;
    if (alarm_n !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: alarm_n=%b expected %b", req, what, alarm_n, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sup_rst_n = 1'b0;
    hb_level = 1'b0; hb_float = 1'b0; supply_low = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b1, 8, "reset state high"); // R8
    supply_low = 1'b1;
    #1;
    check(1'b0, 6, "supply low during reset"); // R6
    supply_low = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; sup_rst_n = 1'b1;
    foreach (VECS[i]) begin
      hb_level   = VECS[i].lvl;
      hb_float   = VECS[i].flt;
      supply_low = VECS[i].sl;
      sup_rst_n  = VECS[i].srst_n;
      repeat (int'(VECS[i].wait_n)) @(posedge clk);
      @(negedge clk);
      check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
    end
    // Directed: asynchronous reset clears a pending timeout (R8).
    repeat (TO + 4) @(negedge clk);
    check(1'b0, 5, "timed out before async reset");
    rst_n = 1'b0;
    #1;
    check(1'b1, 8, "async reset clears alarm");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule